// File: doc/BRIEF.md
# DDR Four-Beat Linear Burst Address Generator

This block produces the internal word addresses for a four-beat double-data-rate burst inside a synchronous SRAM. A one-cycle load strobe captures an external word address while the block is idle. The lowest address bit is always cleared at capture, so a burst begins on an even address. Over the next two clock cycles the block presents four consecutive addresses. Each cycle carries one address for its rising clock edge and one for its falling clock edge.

The two lowest address bits count upward modulo four and wrap back to where they started. All higher bits stay fixed, so a burst never leaves its aligned group of four words. A busy flag covers the two beat cycles, and a done pulse marks the final cycle. A load that arrives while the block is busy is ignored. A new burst can be loaded in the cycle after busy falls. Only linear ordering exists.

Top module: `ddr_burst_addr_gen`

## Requirements
- R1: A synchronous active-low reset clears busy and done and drives both address outputs to zero on the next rising edge. This holds even in the middle of a burst.
- R2: When load is high and busy is low at a rising edge, the address is captured with bit 0 forced to 0. Busy is then high for exactly the next two cycles.
- R3: In the first beat cycle, addr_rise equals the captured even address. addr_fall equals that address with bit 0 set.
- R4: In the second beat cycle, the two low bits of addr_rise equal the start value plus 2 modulo 4. The two low bits of addr_fall equal the start value plus 3 modulo 4. Starting from 00 this gives the order 00, 01, 10, 11. Starting from 10 it gives 10, 11, 00, 01.
- R5: Address bits above bit 1 equal those of the loaded address during the whole burst. No carry from the low bits ever reaches them.
- R6: done is high only during the second beat cycle, for exactly one cycle per burst.
- R7: Busy is low in the cycle after done. A load in that cycle starts a new burst whose first beat appears in the following cycle.
- R8: A load while busy is high is ignored. The running burst's addresses and length are unchanged, and no burst follows it.
- R9: Whenever busy is low, addr_rise and addr_fall are both zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| load | input | 1 | Start strobe for a burst, honoured only when idle |
| addr_in | input | ADDR_W | External word address to capture |
| addr_rise | output | ADDR_W | Address for the rising-edge beat of the current cycle |
| addr_fall | output | ADDR_W | Address for the falling-edge beat of the current cycle |
| busy | output | 1 | High during the two beat cycles of a burst |
| done | output | 1 | High in the last beat cycle of a burst |

## Verification
A beat counter stuck or advanced wrongly shows up in the same cycle. The second-cycle low bits repeat the first pair, or busy lasts one or three cycles, and done lands on the wrong cycle. A wrong wrap of the low bits, or a carry into the upper bits, changes addr_rise or addr_fall in the very beat where it occurs. Starting from 10 and from an all-ones address exposes it within two cycles of the load. If a capture is not gated by busy, a reload corrupts the beat after the ignored strobe. A lost clear of bit 0 appears in the first beat after loading an odd address.

// File: rtl/ddr_burst_pkg.sv
package ddr_burst_pkg;

    // Two address beats leave the block in every clock cycle.
    localparam int unsigned BEATS_PER_CYCLE = 2;

    typedef enum logic {
        PH_IDLE   = 1'b0,
        PH_ACTIVE = 1'b1
    } burst_phase_e;

endpackage

// File: rtl/ddr_burst_ctrl.sv
module ddr_burst_ctrl
    import ddr_burst_pkg::*;
#(
    parameter int unsigned BURST_LEN = 4,
    localparam int unsigned CYCLES   = BURST_LEN / BEATS_PER_CYCLE,
    localparam int unsigned CNT_W    = (CYCLES > 1) ? $clog2(CYCLES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    output logic             accept,
    output logic             busy,
    output logic             last,
    output logic [CNT_W-1:0] cnt
);

    typedef struct packed {
        burst_phase_e     phase;
        logic [CNT_W-1:0] cnt;
    } ctrl_state_t;

    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CYCLES - 1);

    ctrl_state_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        accept = load && (st_q.phase == PH_IDLE);
        last   = (st_q.phase == PH_ACTIVE) && (st_q.cnt == CNT_LAST);
        if (accept) begin
            st_d.phase = PH_ACTIVE;
            st_d.cnt   = '0;
        end else if (st_q.phase == PH_ACTIVE) begin
            if (last) begin
                st_d.phase = PH_IDLE;
                st_d.cnt   = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.phase <= PH_IDLE;
            st_q.cnt   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = (st_q.phase == PH_ACTIVE);
    assign cnt  = st_q.cnt;

    AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !busy) |=> (busy && cnt == '0)) else $error("accept"); // R2
    AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> !busy) else $error("end"); // R7
    AST_LAST_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        last |-> busy) else $error("last"); // R6
    AST_RELOAD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && load && !last) |=> (busy && cnt == $past(cnt) + 1'b1)) else $error("reload"); // R8

endmodule

// File: rtl/ddr_burst_addr.sv
module ddr_burst_addr
    import ddr_burst_pkg::*;
#(
    parameter int unsigned ADDR_W    = 20,
    parameter int unsigned BURST_LEN = 4,
    localparam int unsigned LOW_W    = $clog2(BURST_LEN),
    localparam int unsigned CYCLES   = BURST_LEN / BEATS_PER_CYCLE,
    localparam int unsigned CNT_W    = (CYCLES > 1) ? $clog2(CYCLES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              busy,
    input  logic [CNT_W-1:0]  cnt,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_rise,
    output logic [ADDR_W-1:0] addr_fall
);

    typedef struct packed {
        logic [ADDR_W-1:0] base;
    } addr_state_t;

    addr_state_t st_d, st_q;
    logic [LOW_W-1:0] rise_lo, fall_lo;

    always_comb begin
        st_d = st_q;
        if (accept) begin
            st_d.base = addr_in & ~ADDR_W'(1);
        end
        rise_lo = st_q.base[LOW_W-1:0] + (LOW_W'(cnt) << 1);
        fall_lo = rise_lo | LOW_W'(1);
        if (busy) begin
            addr_rise = {st_q.base[ADDR_W-1:LOW_W], rise_lo};
            addr_fall = {st_q.base[ADDR_W-1:LOW_W], fall_lo};
        end else begin
            addr_rise = '0;
            addr_fall = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.base <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    AST_EVEN_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !addr_rise[0]) else $error("odd rise"); // R3
    AST_FALL_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (addr_fall == (addr_rise | ADDR_W'(1)))) else $error("pair"); // R3
    AST_HIGH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && !$past(accept)) |-> $stable(addr_rise[ADDR_W-1:LOW_W])) else $error("high"); // R5
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (addr_rise == '0 && addr_fall == '0)) else $error("idle"); // R9

endmodule

// File: rtl/ddr_burst_addr_gen.sv
module ddr_burst_addr_gen
    import ddr_burst_pkg::*;
#(
    parameter int unsigned ADDR_W    = 20,
    parameter int unsigned BURST_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_rise,
    output logic [ADDR_W-1:0] addr_fall,
    output logic              busy,
    output logic              done
);

    localparam int unsigned CYCLES = BURST_LEN / BEATS_PER_CYCLE;
    localparam int unsigned CNT_W  = (CYCLES > 1) ? $clog2(CYCLES) : 1;

    logic             accept;
    logic             busy_w;
    logic             last_w;
    logic [CNT_W-1:0] cnt_w;

    ddr_burst_ctrl #(
        .BURST_LEN (BURST_LEN)
    ) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .accept (accept),
        .busy   (busy_w),
        .last   (last_w),
        .cnt    (cnt_w)
    );

    ddr_burst_addr #(
        .ADDR_W    (ADDR_W),
        .BURST_LEN (BURST_LEN)
    ) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .busy      (busy_w),
        .cnt       (cnt_w),
        .addr_in   (addr_in),
        .addr_rise (addr_rise),
        .addr_fall (addr_fall)
    );

    assign busy = busy_w;
    assign done = last_w;

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done)) else $error("reset"); // R1

endmodule

// File: tb/ddr_burst_addr_gen_tb.sv
module ddr_burst_addr_gen_tb;

    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load = 1'b0;
    logic [AW-1:0] addr_in = '0;
    logic [AW-1:0] addr_rise, addr_fall;
    logic          busy, done;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    ddr_burst_addr_gen #(.ADDR_W(AW), .BURST_LEN(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .load(load), .addr_in(addr_in),
        .addr_rise(addr_rise), .addr_fall(addr_fall), .busy(busy), .done(done)
    );

    function automatic logic [AW-1:0] exp_addr(input logic [AW-1:0] a, input int k);
        logic [AW-1:0] b;
        b = a & ~AW'(1);
        return (b & ~AW'(3)) | ((b + AW'(k)) & AW'(3));
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic chk_beat(input string req, input logic [AW-1:0] a, input int cyc);
        chk({req, " busy"}, 32'(busy), 32'd1);
        chk({req, " done"}, 32'(done), 32'(cyc == 1));
        chk({req, " rise"}, 32'(addr_rise), 32'(exp_addr(a, 2 * cyc)));
        chk({req, " fall"}, 32'(addr_fall), 32'(exp_addr(a, 2 * cyc + 1)));
    endtask

    task automatic chk_idle(input string req);
        chk({req, " busy"}, 32'(busy), 32'd0);
        chk({req, " done"}, 32'(done), 32'd0);
        chk({req, " rise"}, 32'(addr_rise), 32'd0);
        chk({req, " fall"}, 32'(addr_fall), 32'd0);
    endtask

    // One full burst followed by an idle check; R2 R3 R4 R5 R6 R7 R9
    task automatic t_burst(input logic [AW-1:0] a, input string req);
        @(negedge clk); load = 1'b1; addr_in = a;
        @(negedge clk); load = 1'b0; addr_in = '0;
        chk_beat({req, " beat0"}, a, 0);
        @(negedge clk);
        chk_beat({req, " beat1"}, a, 1);
        @(negedge clk);
        chk_idle({req, " after R7 R9"});
    endtask

    task automatic t_reset_state();
        chk_idle("R1 reset state");
    endtask

    task automatic t_ignore_busy();
        logic [AW-1:0] a = 20'hA5A52;
        @(negedge clk); load = 1'b1; addr_in = a;
        @(negedge clk); addr_in = 20'h12345;
        chk_beat("R8 beat0", a, 0);
        @(negedge clk); addr_in = 20'h0FFF1;
        chk_beat("R8 beat1", a, 1);
        @(negedge clk); load = 1'b0; addr_in = '0;
        chk_idle("R8 not restarted");
        @(negedge clk);
        chk_idle("R8 still idle");
    endtask

    task automatic t_back_to_back();
        logic [AW-1:0] a = 20'h00104;
        logic [AW-1:0] b = 20'h3333E;
        @(negedge clk); load = 1'b1; addr_in = a;
        @(negedge clk); load = 1'b0;
        chk_beat("R7 first beat0", a, 0);
        @(negedge clk);
        chk_beat("R7 first beat1", a, 1);
        @(negedge clk); load = 1'b1; addr_in = b;
        chk_idle("R7 gap");
        @(negedge clk); load = 1'b0;
        chk_beat("R7 second beat0", b, 0);
        @(negedge clk);
        chk_beat("R7 second beat1", b, 1);
        @(negedge clk);
        chk_idle("R7 second end");
    endtask

    task automatic t_reset_mid();
        @(negedge clk); load = 1'b1; addr_in = 20'h55556;
        @(negedge clk); load = 1'b0; rst_n = 1'b0;
        chk_beat("R1 pre-reset beat0", 20'h55556, 0);
        @(negedge clk);
        chk_idle("R1 mid-burst reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("R1 stays idle");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_burst(20'h12340, "R4 from00");
        t_burst(20'h12342, "R4 from10");
        t_burst(20'h00A01, "R2 odd01");
        t_burst(20'h00A03, "R2 odd11");
        t_burst(20'hFFFFF, "R5 allones");
        t_burst(20'h7FFFE, "R5 carry");
        t_ignore_busy();
        t_back_to_back();
        t_reset_mid();
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule